// File: doc/BRIEF.md
# Recentering Receive Elasticity Buffer

This block sits between a recovered receive clock and the local byte clock of a serial link receiver. On every receive-clock edge it stores one byte with two tags. One tag marks a start delimiter (JK pair) and the other marks an idle pair. On every local-clock edge it presents one stored byte with the same tags. The two clocks differ slightly in frequency. The buffer absorbs the accumulated difference by reading an idle byte twice or by stepping over a redundant idle byte. It never does this to a delimiter or a data byte.

The write pointer crosses into the read domain as a Gray code through a synchronizer chain. The read side measures its separation from that synchronized copy. It keeps the separation near a nominal value. A delimiter leaving the buffer starts a recentering pass over the idle preamble that follows. The line-state logic can assert `line_inactive`; while it is held, a recentering pass is requested every few byte times. If the separation ever leaves its safe window, the read pointer is thrown back to the nominal distance at once and a sticky error flag is raised. A host clears that flag with `err_clr`.

Top module: `rx_elastic_buf`

## Requirements
- R1: While the read reset is asserted, and afterwards until the synchronized separation first reaches NOMINAL_SEP (6), the outputs are idle: `rd_data` = IDLE_CODE (8'hFF), `rd_idle` = 1, `rd_jk` = 0 and `slip_err` = 0.
- R2: Without an error, every byte written with `wr_idle` = 0 comes out exactly once and in write order, with its `rd_jk` tag intact. This covers both data bytes and delimiters.
- R3: When the separation is below LOW_MARK (3) and the entry at the read pointer is idle, that entry is output and the read pointer holds, so one idle is inserted.
- R4: When the separation is above HIGH_MARK (9) and both the current and the next entry are idle, the current entry is output and the read pointer advances by two, so one idle is deleted. The separation therefore stays bounded while the writer is faster.
- R5: A non-idle entry is never repeated or skipped: reading it advances the read pointer by exactly one.
- R6: Outputting a delimiter opens a recentering pass. During that pass, idle entries are inserted or deleted until the separation equals NOMINAL_SEP.
- R7: While `line_inactive` is held, a recentering pass is opened every RECENTER_PERIOD (4) read cycles.
- R8: A separation at or below ERR_LOW (1), or at or above ERR_HIGH (12), sets `slip_err`. The cycle after that, the output is a forced idle. The read pointer is set NOMINAL_SEP entries behind the synchronized write pointer. This holds for both underflow and overflow.
- R9: `slip_err` holds until `err_clr` is seen in a cycle with no new error. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_data | input | DATA_W | Byte stored on each write clock |
| wr_jk | input | 1 | Byte is a start delimiter |
| wr_idle | input | 1 | Byte is an idle pair that may be inserted or deleted |
| rd_clk | input | 1 | Local byte clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| line_inactive | input | 1 | Line state is idle or invalid (read domain) |
| err_clr | input | 1 | Clears the sticky error flag (read domain) |
| rd_data | output | DATA_W | Byte presented on each read clock |
| rd_jk | output | 1 | Presented byte is a delimiter |
| rd_idle | output | 1 | Presented byte is idle |
| slip_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The separation is internal, and the ports never show it directly. The bench infers it from the latency between writing a delimiter and seeing it at the output. To reach the drifted state it needs, the bench runs the writer one percent fast over a long stream of idles with no delimiter and with `line_inactive` low. It then checks that a later delimiter comes out with a short latency, after either a delimiter-triggered pass or a period of `line_inactive`. Overflow and underflow are reached by skewing the writer ten percent and sending long runs with no idle bytes, so no slip is possible.

// File: rtl/eb_pkg.sv
package eb_pkg;
   // What the read side does with its pointer in a given cycle
   typedef enum logic [2:0] {
      ACT_WAIT,   // still filling, present idle
      ACT_START,  // separation reached: begin reading next cycle
      ACT_JUMP,   // out of window: hard recenter, present idle
      ACT_HOLD,   // insert: present entry, keep pointer
      ACT_SKIP,   // delete: present entry, step over next idle
      ACT_STEP    // normal advance
   } rd_act_e;
endpackage

// File: rtl/eb_wr_side.sv
module eb_wr_side #(
   parameter int DW = 8,
   parameter int AW = 4,
   parameter bit RESET_STORE = 1'b1,
   parameter logic [DW-1:0] IDLE_CODE = '1,
   localparam int EW = DW + 2,
   localparam int DEPTH = 1 << AW
) (
   input  logic                wr_clk,
   input  logic                wr_rst_n,
   input  logic [DW-1:0]       wr_data,
   input  logic                wr_jk,
   input  logic                wr_idle,
   output logic [DEPTH*EW-1:0] store_flat,
   output logic [AW:0]         wr_gray
);
   logic [AW:0]   wr_bin;
   logic [AW:0]   wr_bin_nxt;
   logic [EW-1:0] cells [DEPTH];

   assign wr_bin_nxt = wr_bin + (AW+1)'(1);

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else begin
         wr_bin  <= wr_bin_nxt;
         wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
   end

   // Storage variant: cleared to idle on reset, or plain registers
   if (RESET_STORE) begin : g_store_rst
      always_ff @(posedge wr_clk or negedge wr_rst_n) begin
         if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= {1'b0, 1'b1, IDLE_CODE};
         end else begin
            cells[wr_bin[AW-1:0]] <= {wr_jk, wr_idle, wr_data};
         end
      end
   end else begin : g_store_plain
      always_ff @(posedge wr_clk) begin
         cells[wr_bin[AW-1:0]] <= {wr_jk, wr_idle, wr_data};
      end
   end

   for (genvar c = 0; c < DEPTH; c++) begin : g_flat
      assign store_flat[c*EW +: EW] = cells[c];
   end
endmodule

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
   parameter int W = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
   import eb_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4,
   parameter int NOMINAL_SEP = 6,
   parameter int LOW_MARK = 3,
   parameter int HIGH_MARK = 9,
   parameter int ERR_LOW = 1,
   parameter int ERR_HIGH = 12,
   parameter int RECENTER_PERIOD = 4,
   parameter logic [DW-1:0] IDLE_CODE = '1,
   localparam int EW = DW + 2,
   localparam int DEPTH = 1 << AW,
   localparam int PW = AW + 1,
   localparam int CW = (RECENTER_PERIOD > 1) ? $clog2(RECENTER_PERIOD) : 1
) (
   input  logic                rd_clk,
   input  logic                rd_rst_n,
   input  logic [DEPTH*EW-1:0] store_flat,
   input  logic [AW:0]         wr_gray_s,
   input  logic                line_inactive,
   input  logic                err_clr,
   output logic [DW-1:0]       rd_data,
   output logic                rd_jk,
   output logic                rd_idle,
   output logic                slip_err,
   output logic [AW:0]         sep_o,
   output logic [AW:0]         rd_ptr_o,
   output logic                run_o,
   output logic                err_evt_o,
   output logic                cur_idle_o,
   output logic                nxt_idle_o
);
   function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0]   wr_bin_s, rd_ptr, sep;
   logic [AW-1:0] nxt_a;
   logic [EW-1:0] cur;
   logic          nxt_idle, run, pend, err_evt, emit_cur, pend_set, tick_hit;
   logic [CW-1:0] tick;
   rd_act_e       act;

   assign wr_bin_s = gray_to_bin(wr_gray_s);
   assign sep      = wr_bin_s - rd_ptr;
   assign nxt_a    = rd_ptr[AW-1:0] + AW'(1);
   assign cur      = store_flat[int'(rd_ptr[AW-1:0])*EW +: EW];
   assign nxt_idle = store_flat[int'(nxt_a)*EW + DW];
   assign err_evt  = run && ((sep <= PW'(ERR_LOW)) || (sep >= PW'(ERR_HIGH)));
   assign tick_hit = line_inactive && (tick == CW'(RECENTER_PERIOD - 1));

   always_comb begin
      logic want_up, want_dn;
      want_up = (sep < PW'(LOW_MARK)) || (pend && (sep < PW'(NOMINAL_SEP)));
      want_dn = (sep > PW'(HIGH_MARK)) || (pend && (sep > PW'(NOMINAL_SEP)));
      if (!run)                              act = (sep >= PW'(NOMINAL_SEP)) ? ACT_START : ACT_WAIT;
      else if (err_evt)                      act = ACT_JUMP;
      else if (cur[DW] && want_up)           act = ACT_HOLD;
      else if (cur[DW] && nxt_idle && want_dn) act = ACT_SKIP;
      else                                   act = ACT_STEP;
   end

   assign emit_cur = (act == ACT_HOLD) || (act == ACT_SKIP) || (act == ACT_STEP);
   assign pend_set = run && ((emit_cur && cur[DW+1]) || tick_hit);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_ptr   <= '0;
         run      <= 1'b0;
         pend     <= 1'b0;
         tick     <= '0;
         rd_data  <= IDLE_CODE;
         rd_jk    <= 1'b0;
         rd_idle  <= 1'b1;
         slip_err <= 1'b0;
      end else begin
         unique case (act)
            ACT_START: run    <= 1'b1;
            ACT_JUMP:  rd_ptr <= wr_bin_s - PW'(NOMINAL_SEP);
            ACT_SKIP:  rd_ptr <= rd_ptr + PW'(2);
            ACT_STEP:  rd_ptr <= rd_ptr + PW'(1);
            default:   rd_ptr <= rd_ptr;
         endcase
         if (emit_cur) begin
            rd_data <= cur[DW-1:0];
            rd_idle <= cur[DW];
            rd_jk   <= cur[DW+1];
         end else begin
            rd_data <= IDLE_CODE;
            rd_idle <= 1'b1;
            rd_jk   <= 1'b0;
         end
         if (err_evt)      slip_err <= 1'b1;
         else if (err_clr) slip_err <= 1'b0;
         if (line_inactive && run) tick <= tick_hit ? '0 : tick + CW'(1);
         else                      tick <= '0;
         if (!run || act == ACT_JUMP)          pend <= 1'b0;
         else if (pend_set)                    pend <= 1'b1;
         else if (sep == PW'(NOMINAL_SEP))     pend <= 1'b0;
      end
   end

   assign sep_o      = sep;
   assign rd_ptr_o   = rd_ptr;
   assign run_o      = run;
   assign err_evt_o  = err_evt;
   assign cur_idle_o = cur[DW];
   assign nxt_idle_o = nxt_idle;
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int SYNC_STAGES = 2,
   parameter int NOMINAL_SEP = 6,
   parameter int LOW_MARK = 3,
   parameter int HIGH_MARK = 9,
   parameter int ERR_LOW = 1,
   parameter int ERR_HIGH = 12,
   parameter int RECENTER_PERIOD = 4,
   parameter bit RESET_STORE = 1'b1,
   parameter logic [DATA_W-1:0] IDLE_CODE = '1,
   localparam int EW = DATA_W + 2,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_jk,
   input  logic              wr_idle,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              line_inactive,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_jk,
   output logic              rd_idle,
   output logic              slip_err
);
   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (!(ERR_LOW < LOW_MARK && LOW_MARK < NOMINAL_SEP &&
         NOMINAL_SEP < HIGH_MARK && HIGH_MARK < ERR_HIGH)) begin : g_bad_marks
      $error("marks must be strictly ordered around NOMINAL_SEP");
   end
   if (ERR_HIGH > DEPTH - SYNC_STAGES - 1) begin : g_bad_high
      $error("ERR_HIGH leaves no margin for synchronizer lag");
   end
   if (RECENTER_PERIOD < 2) begin : g_bad_period
      $error("RECENTER_PERIOD must be at least 2");
   end

   logic [DEPTH*EW-1:0] store_flat;
   logic [ADDR_W:0]     wr_gray, wr_gray_s, sep_w, rd_ptr_w;
   logic                run_w, err_evt_w, cur_idle_w, nxt_idle_w;

   eb_wr_side #(
      .DW(DATA_W), .AW(ADDR_W), .RESET_STORE(RESET_STORE), .IDLE_CODE(IDLE_CODE)
   ) u_wr (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_jk(wr_jk),
      .wr_idle(wr_idle), .store_flat(store_flat), .wr_gray(wr_gray)
   );

   eb_gray_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
   );

   eb_rd_ctrl #(
      .DW(DATA_W), .AW(ADDR_W), .NOMINAL_SEP(NOMINAL_SEP), .LOW_MARK(LOW_MARK),
      .HIGH_MARK(HIGH_MARK), .ERR_LOW(ERR_LOW), .ERR_HIGH(ERR_HIGH),
      .RECENTER_PERIOD(RECENTER_PERIOD), .IDLE_CODE(IDLE_CODE)
   ) u_rd (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .store_flat(store_flat),
      .wr_gray_s(wr_gray_s), .line_inactive(line_inactive), .err_clr(err_clr),
      .rd_data(rd_data), .rd_jk(rd_jk), .rd_idle(rd_idle), .slip_err(slip_err),
      .sep_o(sep_w), .rd_ptr_o(rd_ptr_w), .run_o(run_w), .err_evt_o(err_evt_w),
      .cur_idle_o(cur_idle_w), .nxt_idle_o(nxt_idle_w)
   );
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
   parameter int PW = 5,
   parameter int LOW_MARK = 3,
   parameter int HIGH_MARK = 9
) (
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          err_clr,
   input logic          run,
   input logic          err_evt,
   input logic          cur_idle,
   input logic          nxt_idle,
   input logic [PW-1:0] sep,
   input logic [PW-1:0] rd_ptr,
   input logic          rd_idle,
   input logic          rd_jk,
   input logic          slip_err
);
   a_r1_fill_idle: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !run |=> rd_idle && !rd_jk);

   a_r3_insert_holds: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      run && !err_evt && cur_idle && (sep < PW'(LOW_MARK)) |=> rd_ptr == $past(rd_ptr));

   a_r4_delete_skips: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      run && !err_evt && cur_idle && nxt_idle && (sep > PW'(HIGH_MARK))
      |=> (rd_ptr - $past(rd_ptr)) == PW'(2));

   a_r5_data_single_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      run && !err_evt && !cur_idle |=> (rd_ptr - $past(rd_ptr)) == PW'(1));

   a_r8_error_idles_output: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      err_evt |=> slip_err && rd_idle && !rd_jk);

   a_r9_flag_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      slip_err && !err_clr |=> slip_err);

   a_r9_flag_clears: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      err_clr && !err_evt |=> !slip_err);
endmodule

bind rx_elastic_buf eb_checker #(
   .PW(ADDR_W + 1), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) u_chk (
   .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .err_clr(err_clr), .run(run_w),
   .err_evt(err_evt_w), .cur_idle(cur_idle_w), .nxt_idle(nxt_idle_w),
   .sep(sep_w), .rd_ptr(rd_ptr_w), .rd_idle(rd_idle), .rd_jk(rd_jk),
   .slip_err(slip_err)
);

// File: tb/rx_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb_top;
   localparam real RD_HALF = 2.0;   // 250 MHz local clock

   logic       wr_clk = 1'b0, rd_clk = 1'b0;
   logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic [7:0] wr_data = 8'hFF;
   logic       wr_jk = 1'b0, wr_idle = 1'b1;
   logic       line_inactive = 1'b0, err_clr = 1'b0;
   logic [7:0] rd_data;
   logic       rd_jk, rd_idle, slip_err;

   real wr_half = 2.0;
   int  n_chk = 0, n_err = 0;
   bit  sb_on = 1'b0, cnt_on = 1'b0, probe_armed = 1'b0;
   int  tx_idle = 0, rx_idle = 0;
   real t_probe = 0.0, lat = 0.0;
   logic [8:0] exp_q[$];
   logic [8:0] exp_v;

   always #(wr_half) wr_clk = ~wr_clk;
   always #(RD_HALF) rd_clk = ~rd_clk;

   rx_elastic_buf dut_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_jk(wr_jk),
      .wr_idle(wr_idle), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .line_inactive(line_inactive), .err_clr(err_clr), .rd_data(rd_data),
      .rd_jk(rd_jk), .rd_idle(rd_idle), .slip_err(slip_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected-value helpers
   function automatic bit lat_in(input real v, input real lo, input real hi);
      return (v >= lo) && (v <= hi);
   endfunction

   task automatic send(input logic [7:0] d, input bit jk, input bit idl);
      @(negedge wr_clk);
      wr_data = d; wr_jk = jk; wr_idle = idl;
      if (cnt_on && idl) tx_idle++;
      if (sb_on && !idl) exp_q.push_back({jk, d});
   endtask

   task automatic send_idles(input int n);
      for (int i = 0; i < n; i++) send(8'hFF, 1'b0, 1'b1);
   endtask

   task automatic send_frame(input int len);
      send(8'h5A, 1'b1, 1'b0);
      for (int i = 0; i < len; i++) send(8'($urandom), 1'b0, 1'b0);
   endtask

   task automatic probe_jk(input real lo, input real hi, input string req);
      @(negedge wr_clk);
      wr_data = 8'hA5; wr_jk = 1'b1; wr_idle = 1'b0;
      if (sb_on) exp_q.push_back({1'b1, 8'hA5});
      t_probe = $realtime + wr_half;
      probe_armed = 1'b1;
      send_idles(1);
      wait (!probe_armed);
      chk(lat_in(lat, lo, hi), req, "delimiter latency x10 cycles",
          int'(lat * 10.0), int'((lo + hi) * 5.0));
   endtask

   // R2 scoreboard and latency probe, sampled away from the active edge
   always @(negedge rd_clk) begin
      if (rd_rst_n) begin
         if (cnt_on && rd_idle) rx_idle++;
         if (probe_armed && rd_jk) begin
            lat = ($realtime - t_probe) / (2.0 * RD_HALF);
            probe_armed = 1'b0;
         end
         if (sb_on && !rd_idle) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "byte with nothing pending", int'({rd_jk, rd_data}), -1);
            end else begin
               exp_v = exp_q.pop_front();
               chk({rd_jk, rd_data} == exp_v, "R2", "byte order/tag",
                   int'({rd_jk, rd_data}), int'(exp_v));
            end
         end
      end
   end

   task automatic skew_phase(input real half, input int nbytes, input bit inact_pre);
      int sent = 0;
      wr_half = half;
      send_idles(20);
      tx_idle = 0; rx_idle = 0; cnt_on = 1'b1;
      while (sent < nbytes) begin
         int pre = $urandom_range(4, 12);
         int len = $urandom_range(8, 60);
         line_inactive = inact_pre;
         send_idles(pre);
         line_inactive = 1'b0;
         send_frame(len);
         sent += pre + len + 1;
      end
      cnt_on = 1'b0;
      send_idles(40);
      chk(exp_q.size() == 0, "R2", "bytes left undelivered", exp_q.size(), 0);
      chk(slip_err == 1'b0, "R8", "no error under small skew", int'(slip_err), 0);
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20250611));
      repeat (3) @(negedge rd_clk);
      chk(rd_idle && !rd_jk && rd_data == 8'hFF, "R1", "outputs in reset",
          int'({rd_idle, rd_jk, rd_data}), int'({2'b10, 8'hFF}));
      chk(slip_err == 1'b0, "R1", "error flag in reset", int'(slip_err), 0);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      sb_on = 1'b1;
      @(negedge rd_clk); @(negedge rd_clk);
      chk(rd_idle && !rd_jk && rd_data == 8'hFF && !slip_err, "R1", "fill outputs",
          int'({rd_idle, rd_jk, rd_data}), int'({2'b10, 8'hFF}));
      send_idles(30);

      // R3: writer 1% slow, reader must insert idles
      skew_phase(2.02, 5000, 1'b0);
      chk(rx_idle - tx_idle > 20, "R3", "idles inserted (rx-tx)", rx_idle - tx_idle, 50);
      // R4: writer 1% fast, reader must delete idles; preambles also under line_inactive
      skew_phase(1.98, 5000, 1'b1);
      chk(tx_idle - rx_idle > 20, "R4", "idles deleted (tx-rx)", tx_idle - rx_idle, 50);

      // Drift high with no recentering, then probe
      line_inactive = 1'b0;
      send_idles(900);
      probe_jk(10.2, 14.5, "R4");
      for (int i = 0; i < 12; i++) send(8'($urandom), 1'b0, 1'b0);
      send_idles(24);
      probe_jk(5.5, 10.0, "R6");
      send_idles(900);
      line_inactive = 1'b1;
      send_idles(60);
      line_inactive = 1'b0;
      probe_jk(5.5, 10.0, "R7");
      send_idles(40);
      chk(exp_q.size() == 0, "R2", "bytes left after probes", exp_q.size(), 0);
      chk(slip_err == 1'b0, "R5", "no error during probes", int'(slip_err), 0);

      // R8 overflow: fast writer, no idles to delete
      sb_on = 1'b0;
      wr_half = 1.8;
      for (int i = 0; i < 200; i++) send(8'($urandom), 1'b0, 1'b0);
      chk(slip_err == 1'b1, "R8", "overflow flagged", int'(slip_err), 1);
      wr_half = 2.0;
      line_inactive = 1'b1;
      send_idles(60);
      chk(slip_err == 1'b1, "R9", "flag sticky before clear", int'(slip_err), 1);
      @(negedge rd_clk); err_clr = 1'b1;
      @(negedge rd_clk); err_clr = 1'b0;
      @(negedge rd_clk);
      chk(slip_err == 1'b0, "R9", "flag cleared", int'(slip_err), 0);
      line_inactive = 1'b0;

      // R8 underflow: slow writer, no idles to insert
      wr_half = 2.2;
      for (int i = 0; i < 150; i++) send(8'($urandom), 1'b0, 1'b0);
      chk(slip_err == 1'b1, "R8", "underflow flagged", int'(slip_err), 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule